// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block translates a 32-bit effective address by walking a hashed page table held in memory. It is given a 24-bit segment virtual ID (`vsid`), the effective address, whether the access is a store, and the table base and mask. From these it forms a compare tag and a hash, and probes the eight entries of the primary group in ascending order. If none of them matches, it probes the eight entries of the group addressed by the complemented hash. Each entry is two 32-bit words.

On a match it reads the entry's second word and sets the referenced bit. On a store it also sets the changed bit. It writes that word back only if it changed, and then reports:

- the entry address,
- both entry words, with the second word as updated,
- the real address,
- whether stores may be allowed.

A miss in both groups reports not-found. Every walk ends with a one-cycle `done` pulse.

The memory side is a word port. `mem_req` holds the request with its address, write enable and write data until `mem_ack`. On a read, `mem_rdata` is valid in the `mem_ack` cycle.

The control is one state machine with these states:

- **IDLE** waits for `start` and latches the inputs.
- **PROBE** reads the first word of the current entry.
  - On a match it goes to **FETCH**.
  - On a miss it advances to the next entry.
  - After the last primary entry it switches to the secondary pass and stays in PROBE.
  - After the last secondary entry it goes to **FINISH** with not-found.
- **FETCH** reads the second word. It goes to **WRITEBACK** if the word changes, and otherwise to **FINISH**.
- **WRITEBACK** stores the updated second word and goes to **FINISH** on acknowledge.
- **FINISH** pulses `done` and returns to **IDLE**.

Top module: `hpt_walker`

## Requirements
- R1: The page index is `eaddr[27:12]`, and the tag's short page field is page index bits 15:10. The primary hash is the low 19 bits of `vsid` XOR the zero-extended page index. The first word of the primary group is at `base + ((hash << 6) & mask)`.
- R2: The eight entries of a group are probed in ascending order. Entry i's first word is at group + 8·i and its second word at group + 8·i + 4. An address with a pending request stays stable until acknowledged.
- R3: An entry matches only if all of these hold in word 0:
  - bit 31 (valid) is 1;
  - bit 6 (secondary select) equals the pass (0 primary, 1 secondary);
  - bits 30:7 equal `vsid`;
  - bits 5:0 equal the short page field.
  Matching entries with other values of these bits are skipped.
- R4: If the primary group has no match, the secondary group at `base + ((~hash[18:0] << 6) & mask)` is searched the same way.
- R5: On a hit the returned word 1 has the referenced bit (bit 8) set. The changed bit (bit 7) is set when `is_write` is 1 and otherwise keeps its value from memory.
- R6: Word 1 is written back to the entry's second-word address only if the updated value differs from the value read. Otherwise no write takes place.
- R7: `wr_ok` is 1 on a hit when the access is a store or when the changed bit read from memory was already 1. Otherwise it is 0.
- R8: The real address is word 1 bits 31:12 joined with `eaddr[11:0]`.
- R9: A miss in both groups gives `not_found`=1 and `hit`=0. Each walk gives exactly one one-cycle `done`, with exactly one of `hit` and `not_found` set.
- R10: After reset the block is idle: `done`=0 and `mem_req`=0 until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| vsid | input | 24 | Segment virtual ID |
| eaddr | input | 32 | Effective address |
| is_write | input | 1 | Access is a store |
| tbl_base | input | 32 | Table base byte address |
| tbl_mask | input | 32 | Group offset mask |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Entry found |
| not_found | output | 1 | Both groups missed |
| pte_addr | output | 32 | Byte address of the found entry |
| pte_w0 | output | 32 | First word of the found entry |
| pte_w1 | output | 32 | Updated second word |
| real_addr | output | 32 | Translated address |
| wr_ok | output | 1 | Stores may be allowed for this page |

## Verification
The bench places decoy entries that each fail one match term: a clear valid bit, a wrong secondary-select bit, or a wrong tag. A design that drops any term returns the decoy's address instead of the real entry's. Hits at entry 0 and at entry 7 catch off-by-one walks. A hit that exists only in the complemented-hash group catches a design that stops after the primary pass or hashes the secondary group wrongly. Write-back is checked by counting memory writes: a read of an entry with R and C already set must cause none, and a read of a clean entry must write R without C and withhold write permission.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int VSID_W   = 24;
    localparam int HASH_W   = 19;
    localparam int PGIDX_W  = 16;
    localparam int API_W    = 6;
    localparam int PAGE_SH  = 12;
    localparam int VALID_B  = 31;
    localparam int SEC_B    = 6;
    localparam int REF_B    = 8;
    localparam int CHG_B    = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROBE,
        S_FETCH,
        S_WRITEBACK,
        S_FINISH
    } walk_state_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int AW        = 32,
    parameter int GRP_BYTES = 64
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [AW-1:0]     eaddr,
    input  logic              pass,
    input  logic [AW-1:0]     tbl_base,
    input  logic [AW-1:0]     tbl_mask,
    output logic [API_W-1:0]  api,
    output logic [AW-1:0]     grp_addr
);
    localparam int GRP_SH = $clog2(GRP_BYTES);

    logic [PGIDX_W-1:0] pgidx;
    logic [HASH_W-1:0]  hash_p;
    logic [HASH_W-1:0]  hash_sel;
    logic [AW-1:0]      offs;

    always_comb begin
        pgidx    = eaddr[PAGE_SH +: PGIDX_W];
        api      = pgidx[PGIDX_W-1 -: API_W];
        hash_p   = vsid[HASH_W-1:0] ^ HASH_W'(pgidx);
        hash_sel = pass ? ~hash_p : hash_p;
        offs     = (AW'(hash_sel) << GRP_SH) & tbl_mask;
        grp_addr = tbl_base + offs;
    end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
    import hpt_pkg::*;
(
    input  logic [31:0]       word0,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              pass,
    output logic              match
);
    always_comb begin
        match = word0[VALID_B]
             && (word0[SEC_B] == pass)
             && (word0[30:7] == vsid)
             && (word0[API_W-1:0] == api);
    end
endmodule

// File: rtl/hpt_update.sv
module hpt_update
    import hpt_pkg::*;
(
    input  logic [31:0] word1,
    input  logic        is_write,
    output logic [31:0] new_word1,
    output logic        need_wb,
    output logic        wr_ok
);
    always_comb begin
        new_word1        = word1;
        new_word1[REF_B] = 1'b1;
        if (is_write)
            new_word1[CHG_B] = 1'b1;
        need_wb = (new_word1 != word1);
        wr_ok   = is_write | word1[CHG_B];
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int AW        = 32,
    parameter int WAYS      = 8,
    parameter int ENT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VSID_W-1:0] vsid,
    input  logic [AW-1:0]     eaddr,
    input  logic              is_write,
    input  logic [AW-1:0]     tbl_base,
    input  logic [AW-1:0]     tbl_mask,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic              hit,
    output logic              not_found,
    output logic [AW-1:0]     pte_addr,
    output logic [31:0]       pte_w0,
    output logic [31:0]       pte_w1,
    output logic [AW-1:0]     real_addr,
    output logic              wr_ok
);
    localparam int GRP_BYTES = WAYS * ENT_BYTES;
    localparam int IDX_W     = $clog2(WAYS);
    localparam int W1_OFF    = ENT_BYTES / 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WAYS - 1);

    walk_state_t state, state_nx;

    logic [VSID_W-1:0] vsid_q;
    logic [AW-1:0]     ea_q, base_q, mask_q;
    logic              we_q, pass_q;
    logic [IDX_W-1:0]  idx_q;
    logic [API_W-1:0]  api;
    logic [AW-1:0]     grp_addr, ent_addr;
    logic              match;
    logic [31:0]       new_w1;
    logic              need_wb, wr_ok_c;

    hpt_hash #(.AW(AW), .GRP_BYTES(GRP_BYTES)) u_hash (
        .vsid     (vsid_q),
        .eaddr    (ea_q),
        .pass     (pass_q),
        .tbl_base (base_q),
        .tbl_mask (mask_q),
        .api      (api),
        .grp_addr (grp_addr)
    );

    hpt_match u_match (
        .word0 (mem_rdata),
        .vsid  (vsid_q),
        .api   (api),
        .pass  (pass_q),
        .match (match)
    );

    hpt_update u_upd (
        .word1     (mem_rdata),
        .is_write  (we_q),
        .new_word1 (new_w1),
        .need_wb   (need_wb),
        .wr_ok     (wr_ok_c)
    );

    assign ent_addr = grp_addr + AW'(idx_q) * AW'(ENT_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (start) state_nx = S_PROBE;
            S_PROBE:     if (mem_ack) begin
                             if (match)                          state_nx = S_FETCH;
                             else if (idx_q == LAST_IDX && pass_q) state_nx = S_FINISH;
                         end
            S_FETCH:     if (mem_ack) state_nx = need_wb ? S_WRITEBACK : S_FINISH;
            S_WRITEBACK: if (mem_ack) state_nx = S_FINISH;
            S_FINISH:    state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsid_q <= '0; ea_q <= '0; base_q <= '0; mask_q <= '0;
            we_q <= 1'b0; pass_q <= 1'b0; idx_q <= '0;
            hit <= 1'b0; not_found <= 1'b0; pte_addr <= '0;
            pte_w0 <= '0; pte_w1 <= '0; real_addr <= '0; wr_ok <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    vsid_q <= vsid; ea_q <= eaddr; we_q <= is_write;
                    base_q <= tbl_base; mask_q <= tbl_mask;
                    pass_q <= 1'b0; idx_q <= '0;
                    hit <= 1'b0; not_found <= 1'b0; wr_ok <= 1'b0;
                end
                S_PROBE: if (mem_ack) begin
                    if (match) begin
                        pte_addr <= ent_addr;
                        pte_w0   <= mem_rdata;
                    end else if (idx_q == LAST_IDX) begin
                        idx_q <= '0;
                        if (pass_q) not_found <= 1'b1;
                        else        pass_q    <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                S_FETCH: if (mem_ack) begin
                    hit       <= 1'b1;
                    pte_w1    <= new_w1;
                    wr_ok     <= wr_ok_c;
                    real_addr <= {mem_rdata[AW-1:PAGE_SH], ea_q[PAGE_SH-1:0]};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state)
            S_PROBE:     begin mem_req = 1'b1; mem_addr = ent_addr; end
            S_FETCH:     begin mem_req = 1'b1; mem_addr = pte_addr + AW'(W1_OFF); end
            S_WRITEBACK: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = pte_addr + AW'(W1_OFF); mem_wdata = pte_w1;
            end
            S_FINISH:    done = 1'b1;
            default: ;
        endcase
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hit ^ not_found));
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R5
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[REF_B]);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!mem_req && !done));
endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] vsid = '0;
    logic [31:0] eaddr = '0;
    logic        is_write = 1'b0;
    logic [31:0] tbl_base = 32'h0;
    logic [31:0] tbl_mask = 32'h3C0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, hit, not_found, wr_ok;
    logic [31:0] pte_addr, pte_w0, pte_w1, real_addr;

    logic [31:0] mem [0:255];
    int          wr_cnt;
    logic [31:0] wr_addr, wr_data;
    int          errs = 0;
    int          checks = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    hpt_walker i_hpt_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .eaddr(eaddr),
        .is_write(is_write), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .hit(hit), .not_found(not_found), .pte_addr(pte_addr),
        .pte_w0(pte_w0), .pte_w1(pte_w1), .real_addr(real_addr), .wr_ok(wr_ok)
    );

    initial mem_ack = 1'b0;
    initial begin wr_cnt = 0; wr_addr = '0; wr_data = '0; end
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                wr_cnt  <= wr_cnt + 1;
                wr_addr <= mem_addr;
                wr_data <= mem_wdata;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end
    assign mem_rdata = mem_ack ? mem[mem_addr[9:2]] : 32'h0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] hash_of(input logic [23:0] v, input logic [31:0] ea);
        return v[18:0] ^ {3'b0, ea[27:12]};
    endfunction
    function automatic logic [31:0] grp(input logic [18:0] h);
        return tbl_base + (({13'b0, h} << 6) & tbl_mask);
    endfunction
    function automatic logic [31:0] mk_w0(input logic v, input logic sec,
                                          input logic [23:0] vs, input logic [31:0] ea);
        return {v, vs, sec, ea[27:22]};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask
    task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a[9:2]]     = w0;
        mem[a[9:2] + 1] = w1;
    endtask

    task automatic walk(input logic [23:0] v, input logic [31:0] ea, input logic wr);
        int n;
        @(negedge clk);
        vsid = v; eaddr = ea; is_write = wr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) begin
            errs++; checks++;
            $display("FAIL R9: no done, actual=0 expected=1");
        end
    endtask

    task automatic t_reset();
        chk("R10 done idle", {31'b0, done}, 32'h0);
        chk("R10 req idle", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_primary_read_clean();
        logic [23:0] v = 24'h000123;
        logic [31:0] ea = 32'h1004_5678;
        logic [31:0] g = grp(hash_of(v, ea));
        int w0c;
        clear_mem();
        put(g, mk_w0(1, 0, v, ea), 32'hABCDE002);
        w0c = wr_cnt;
        walk(v, ea, 1'b0);
        chk("R1/R3 hit", {31'b0, hit}, 32'h1);
        chk("R1 entry addr", pte_addr, g);
        chk("R5 ref set, chg clear", pte_w1, 32'hABCDE102);
        chk("R7 wr_ok withheld", {31'b0, wr_ok}, 32'h0);
        chk("R8 real addr", real_addr, 32'hABCDE678);
        @(negedge clk);
        chk("R9 done one cycle", {31'b0, done}, 32'h0);
        chk("R6 one write", 32'(wr_cnt - w0c), 32'd1);
        chk("R6 write addr", wr_addr, g + 32'd4);
        chk("R6 write data", wr_data, 32'hABCDE102);
    endtask

    task automatic t_decoys_last_entry();
        logic [23:0] v = 24'h0A5F31;
        logic [31:0] ea = 32'h0C38_0ABC;
        logic [31:0] g = grp(hash_of(v, ea));
        int w0c;
        clear_mem();
        put(g + 0,  mk_w0(0, 0, v, ea), 32'h11111180);
        put(g + 8,  mk_w0(1, 1, v, ea), 32'h22222180);
        put(g + 16, mk_w0(1, 0, v ^ 24'h1, ea), 32'h33333180);
        put(g + 24, mk_w0(1, 0, v, ea ^ 32'h0400_0000), 32'h44444180);
        put(g + 56, mk_w0(1, 0, v, ea), 32'h55555183);
        w0c = wr_cnt;
        walk(v, ea, 1'b0);
        chk("R3 decoys skipped, hit", {31'b0, hit}, 32'h1);
        chk("R2 last entry addr", pte_addr, g + 32'd56);
        chk("R2 word0 returned", pte_w0, mk_w0(1, 0, v, ea));
        chk("R7 wr_ok when C set", {31'b0, wr_ok}, 32'h1);
        chk("R5 word unchanged", pte_w1, 32'h55555183);
        chk("R8 real addr", real_addr, 32'h55555ABC);
        chk("R6 no write", 32'(wr_cnt - w0c), 32'd0);
    endtask

    task automatic t_secondary_write();
        logic [23:0] v = 24'h3C0007;
        logic [31:0] ea = 32'h0001_2345;
        logic [18:0] h = hash_of(v, ea);
        logic [31:0] g2 = grp(~h);
        int w0c;
        clear_mem();
        put(grp(h) + 16, mk_w0(1, 1, v, ea), 32'h99999000);
        put(g2 + 24, mk_w0(1, 1, v, ea), 32'h0FEDC001);
        w0c = wr_cnt;
        walk(v, ea, 1'b1);
        chk("R4 secondary hit", {31'b0, hit}, 32'h1);
        chk("R4 secondary addr", pte_addr, g2 + 32'd24);
        chk("R5 ref and chg on write", pte_w1, 32'h0FEDC181);
        chk("R7 wr_ok on write", {31'b0, wr_ok}, 32'h1);
        chk("R6 write data", wr_data, 32'h0FEDC181);
        chk("R6 write count", 32'(wr_cnt - w0c), 32'd1);
    endtask

    task automatic t_miss();
        logic [23:0] v = 24'h000F00;
        logic [31:0] ea = 32'h7777_7000;
        int w0c;
        clear_mem();
        put(grp(hash_of(v, ea)), mk_w0(1, 1, v, ea), 32'h1);
        put(grp(~hash_of(v, ea)), mk_w0(1, 0, v, ea), 32'h1);
        w0c = wr_cnt;
        walk(v, ea, 1'b0);
        chk("R9 not_found", {31'b0, not_found}, 32'h1);
        chk("R9 no hit", {31'b0, hit}, 32'h0);
        @(negedge clk);
        chk("R9 done pulse", {31'b0, done}, 32'h0);
        chk("R6 miss no write", 32'(wr_cnt - w0c), 32'd0);
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_primary_read_clean();
        t_decoys_last_entry();
        t_secondary_write();
        t_miss();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule